// File: doc/BRIEF.md
# Programmable blanking window generator

This block produces a blanking strobe that tells an upstream pixel source when to stop delivering pixel data and when to start again. A horizontal pixel counter restarts at every horizontal sync leading edge. A line counter restarts at the vertical sync leading edge that opens an odd field. Both counters are compared against programmable bounds. The strobe is asserted whenever either the horizontal window or the vertical window says the current position is blanked.

The vertical bounds are programmed once, as line numbers for the odd field. For even fields the block adds a fixed offset that depends on the line standard: 262 lines for the 525-line system and 313 lines for the 625-line system. All bounds are loaded through a byte-wide write port. A value wider than one byte takes effect only when its upper byte is written, so the comparators never see a half-updated value.

A control bit chooses whether the block drives the strobe at all. While that bit is clear, the strobe is held low, the output-enable qualifier is low, and the programmed bounds have no effect on any output. Only plain control pins are involved; there is no streaming data interface, so no back-pressure rules apply.

Top module: `blank_window_gen`

## Requirements
- R1: After reset, `blank` and `blank_oe` are low and the settings hold their defaults: horizontal start 0x34A, horizontal end 0x7A, vertical start 3, vertical end 22, last pixel count of a line 857, and drive disabled.
- R2: The pixel counter is 0 in the clock after `hsync_lead` is sampled high. Otherwise it advances by one per clock. After it reaches the programmed last pixel count, it returns to 0.
- R3: A position is horizontally blanked when the pixel counter is at or above the horizontal start, or below the horizontal end.
- R4: The line counter becomes 0 when `vsync_lead` is sampled high while `field_odd` is high. Otherwise each sampled `hsync_lead` advances it by one. The vertical reset wins when both pulses arrive in the same clock.
- R5: In an odd field (`field_odd` = 1), a line is vertically blanked when its line count is at or above the vertical start and below the vertical end.
- R6: In an even field (`field_odd` = 0), both vertical bounds are raised by 262 when `std_625` = 0 and by 313 when `std_625` = 1.
- R7: `blank` is registered. In each clock it shows the OR of the horizontal and vertical window conditions, evaluated on the counter values of the previous clock.
- R8: Write addresses: 0 horizontal start low byte, 1 horizontal start bits [9:8] in data bits [1:0], 2 horizontal end, 3 vertical start low byte, 4 vertical start bit 8 in data bit 0, 5 vertical end low byte, 6 vertical end bit 8 in data bit 0, 7 control (bit 0 = drive enable), 8 last pixel count low byte, 9 last pixel count bits [9:8]. A low-byte write is only staged. The whole value changes when its high byte is written.
- R9: While drive enable is 0, `blank` and `blank_oe` are low whatever the counters and bounds are. `blank_oe` follows the drive enable bit one clock after the bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| hsync_lead | input | 1 | One-clock pulse at the horizontal sync leading edge |
| vsync_lead | input | 1 | One-clock pulse at the vertical sync leading edge |
| field_odd | input | 1 | High during an odd field |
| std_625 | input | 1 | High selects the 625-line standard, low the 525-line standard |
| blank | output | 1 | Blanking strobe: pixel input is not accepted while it is high |
| blank_oe | output | 1 | High while the block drives `blank` |

## Verification
The main function is tested by reaching chosen pairs of line and pixel position and sampling the strobe. Pixel positions sit on each side of the horizontal start and end, and distinguish the wrap-around OR window from an in-range window. Line positions sit on each side of the vertical start and end in odd fields and in even fields of both standards, which separates the missing offset and the wrong offset from the correct 262 or 313. One sample taken after the pixel counter has wrapped separates a counter that wraps at the programmed length from one that keeps counting. The exact bound checks also show the one-clock register stage, because an unregistered strobe would report the next pixel's condition.

// File: rtl/blank_pkg.sv
package blank_pkg;
  // Register addresses of the configuration write port
  localparam logic [3:0] A_HSTART_LO = 4'd0;
  localparam logic [3:0] A_HSTART_HI = 4'd1;
  localparam logic [3:0] A_HEND      = 4'd2;
  localparam logic [3:0] A_VSTART_LO = 4'd3;
  localparam logic [3:0] A_VSTART_HI = 4'd4;
  localparam logic [3:0] A_VEND_LO   = 4'd5;
  localparam logic [3:0] A_VEND_HI   = 4'd6;
  localparam logic [3:0] A_CTRL      = 4'd7;
  localparam logic [3:0] A_LLAST_LO  = 4'd8;
  localparam logic [3:0] A_LLAST_HI  = 4'd9;

  // Even-field offsets for the two line standards
  localparam int unsigned EVEN_OFS_525 = 262;
  localparam int unsigned EVEN_OFS_625 = 313;
endpackage

// File: rtl/blank_regs.sv
module blank_regs
  import blank_pkg::*;
#(
  parameter int HW  = 10,
  parameter int HEW = 8,
  parameter int VSW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [3:0]     addr,
  input  logic [7:0]     wdata,
  output logic [HW-1:0]  hstart,
  output logic [HEW-1:0] hend,
  output logic [VSW-1:0] vstart,
  output logic [VSW-1:0] vend,
  output logic [HW-1:0]  line_last,
  output logic           drive_en
);
  localparam int HHI = HW - 8;
  localparam int VHI = VSW - 8;

  logic [7:0] hs_lo_q, vs_lo_q, ve_lo_q, ll_lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_lo_q   <= 8'h4A;
      vs_lo_q   <= 8'h03;
      ve_lo_q   <= 8'h16;
      ll_lo_q   <= 8'h59;
      hstart    <= HW'(10'h34A);
      hend      <= HEW'(8'h7A);
      vstart    <= VSW'(9'd3);
      vend      <= VSW'(9'd22);
      line_last <= HW'(10'd857);
      drive_en  <= 1'b0;
    end else if (wr) begin
      unique case (addr)
        A_HSTART_LO: hs_lo_q <= wdata;
        A_HSTART_HI: hstart  <= {wdata[HHI-1:0], hs_lo_q};
        A_HEND:      hend    <= wdata[HEW-1:0];
        A_VSTART_LO: vs_lo_q <= wdata;
        A_VSTART_HI: vstart  <= {wdata[VHI-1:0], vs_lo_q};
        A_VEND_LO:   ve_lo_q <= wdata;
        A_VEND_HI:   vend    <= {wdata[VHI-1:0], ve_lo_q};
        A_CTRL:      drive_en <= wdata[0];
        A_LLAST_LO:  ll_lo_q <= wdata;
        A_LLAST_HI:  line_last <= {wdata[HHI-1:0], ll_lo_q};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/blank_counters.sv
module blank_counters #(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_lead,
  input  logic          vsync_lead,
  input  logic          field_odd,
  input  logic [HW-1:0] line_last,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                hcnt <= '0;
    else if (hsync_lead)       hcnt <= '0;
    else if (hcnt == line_last) hcnt <= '0;
    else                       hcnt <= hcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       vcnt <= '0;
    else if (vsync_lead && field_odd) vcnt <= '0;
    else if (hsync_lead)              vcnt <= vcnt + 1'b1;
  end
endmodule

// File: rtl/blank_window.sv
module blank_window
  import blank_pkg::*;
#(
  parameter int HW  = 10,
  parameter int HEW = 8,
  parameter int VW  = 10,
  parameter int VSW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HW-1:0]  hcnt,
  input  logic [VW-1:0]  vcnt,
  input  logic [HW-1:0]  hstart,
  input  logic [HEW-1:0] hend,
  input  logic [VSW-1:0] vstart,
  input  logic [VSW-1:0] vend,
  input  logic           field_odd,
  input  logic           std_625,
  input  logic           drive_en,
  output logic           blank,
  output logic           blank_oe
);
  logic [VW-1:0] ofs, vs_eff, ve_eff;
  logic          h_win, v_win;

  always_comb begin
    if (field_odd)    ofs = '0;
    else if (std_625) ofs = VW'(EVEN_OFS_625);
    else              ofs = VW'(EVEN_OFS_525);
    vs_eff = VW'(vstart) + ofs;
    ve_eff = VW'(vend) + ofs;
    h_win  = (hcnt >= hstart) || (hcnt < HW'(hend));
    v_win  = (vcnt >= vs_eff) && (vcnt < ve_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank    <= 1'b0;
      blank_oe <= 1'b0;
    end else begin
      blank    <= drive_en && (h_win || v_win);
      blank_oe <= drive_en;
    end
  end
endmodule

// File: rtl/blank_window_gen.sv
module blank_window_gen #(
  parameter int HW  = 10,
  parameter int HEW = 8,
  parameter int VW  = 10,
  parameter int VSW = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [3:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       hsync_lead,
  input  logic       vsync_lead,
  input  logic       field_odd,
  input  logic       std_625,
  output logic       blank,
  output logic       blank_oe
);
  logic [HW-1:0]  hstart, line_last, hcnt;
  logic [HEW-1:0] hend;
  logic [VSW-1:0] vstart, vend;
  logic [VW-1:0]  vcnt;
  logic           drive_en;

  blank_regs #(.HW(HW), .HEW(HEW), .VSW(VSW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .hstart(hstart), .hend(hend), .vstart(vstart), .vend(vend),
    .line_last(line_last), .drive_en(drive_en)
  );

  blank_counters #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hsync_lead(hsync_lead), .vsync_lead(vsync_lead),
    .field_odd(field_odd), .line_last(line_last), .hcnt(hcnt), .vcnt(vcnt)
  );

  blank_window #(.HW(HW), .HEW(HEW), .VW(VW), .VSW(VSW)) u_win (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .hstart(hstart),
    .hend(hend), .vstart(vstart), .vend(vend), .field_odd(field_odd),
    .std_625(std_625), .drive_en(drive_en), .blank(blank), .blank_oe(blank_oe)
  );
endmodule

// File: rtl/blank_window_chk.sv
module blank_window_chk #(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [3:0]    cfg_addr,
  input logic          hsync_lead,
  input logic          vsync_lead,
  input logic          field_odd,
  input logic [HW-1:0] hcnt,
  input logic [HW-1:0] hstart,
  input logic [HW-1:0] line_last,
  input logic [VW-1:0] vcnt,
  input logic          drive_en,
  input logic          blank,
  input logic          blank_oe
);
  // R2
  hsync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_lead |=> (hcnt == '0));

  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_lead && hcnt == line_last) |=> (hcnt == '0));

  // R4
  field_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_lead && field_odd) |=> (vcnt == '0));

  // R8
  hstart_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_addr == 4'd1) |=> $stable(hstart));

  // R9
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_oe |-> !blank);

  // R9
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_en) |=> !blank_oe);
endmodule

bind blank_window_gen blank_window_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .hsync_lead(hsync_lead), .vsync_lead(vsync_lead), .field_odd(field_odd),
  .hcnt(hcnt), .hstart(hstart), .line_last(line_last), .vcnt(vcnt),
  .drive_en(drive_en), .blank(blank), .blank_oe(blank_oe)
);

// File: tb/test_blank_window_gen.sv
module test_blank_window_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       hsync_lead = 1'b0;
  logic       vsync_lead = 1'b0;
  logic       field_odd = 1'b1;
  logic       std_625 = 1'b0;
  logic       blank, blank_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  blank_window_gen i_blank_window_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hsync_lead(hsync_lead), .vsync_lead(vsync_lead),
    .field_odd(field_odd), .std_625(std_625), .blank(blank), .blank_oe(blank_oe)
  );

  // Bench setup: hstart 40, hend 8, vstart 5, vend 9, last pixel 63.
  // Vector fields: line[20:11], odd[10], std625[9], pixel[8:1], expected[0]
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {10'd1,   1'b1, 1'b0, 8'd20, 1'b0},  // R3 mid-line active
    {10'd1,   1'b1, 1'b0, 8'd7,  1'b1},  // R3 R7 last blanked before end
    {10'd1,   1'b1, 1'b0, 8'd8,  1'b0},  // R3 R7 end bound
    {10'd1,   1'b1, 1'b0, 8'd39, 1'b0},  // R3 R7 just before start
    {10'd1,   1'b1, 1'b0, 8'd40, 1'b1},  // R3 start bound
    {10'd5,   1'b1, 1'b0, 8'd20, 1'b1},  // R5 vertical start
    {10'd4,   1'b1, 1'b0, 8'd20, 1'b0},  // R5 before start
    {10'd9,   1'b1, 1'b0, 8'd20, 1'b0},  // R5 vertical end
    {10'd8,   1'b1, 1'b0, 8'd20, 1'b1},  // R5 last blanked line
    {10'd5,   1'b0, 1'b0, 8'd20, 1'b0},  // R6 even: no unshifted window
    {10'd267, 1'b0, 1'b0, 8'd20, 1'b1},  // R6 525 offset start
    {10'd266, 1'b0, 1'b0, 8'd20, 1'b0},  // R6 525 before start
    {10'd267, 1'b0, 1'b1, 8'd20, 1'b0},  // R6 625 not at 525 offset
    {10'd318, 1'b0, 1'b1, 8'd20, 1'b1},  // R6 625 offset start
    {10'd322, 1'b0, 1'b1, 8'd20, 1'b0}   // R6 625 offset end
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Reach a line and pixel position, then sample blank for that position
  task automatic go_to(input int line, input logic odd, input logic s625, input int pix);
    @(negedge clk);
    field_odd = 1'b1; vsync_lead = 1'b1; hsync_lead = 1'b1;
    @(negedge clk);
    vsync_lead = 1'b0; field_odd = odd; std_625 = s625;
    repeat (line) @(negedge clk);
    hsync_lead = 1'b0;
    repeat (pix + 1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(blank, 1'b0, "R1 blank at reset");
    check(blank_oe, 1'b0, "R1 oe at reset");

    // Drive enable, defaults still loaded
    wr(4'd7, 8'h01);
    @(negedge clk);
    check(blank_oe, 1'b1, "R9 oe follows enable");
    go_to(1, 1'b1, 1'b0, 200);
    check(blank, 1'b0, "R1 default window open at pixel 200");
    go_to(1, 1'b1, 1'b0, 100);
    check(blank, 1'b1, "R1 default hend 0x7A");
    go_to(3, 1'b1, 1'b0, 200);
    check(blank, 1'b1, "R1 default vstart 3");

    // Bench setup via R8 map
    wr(4'd0, 8'd40);  wr(4'd1, 8'd0);
    wr(4'd2, 8'd8);
    wr(4'd3, 8'd5);   wr(4'd4, 8'd0);
    wr(4'd5, 8'd9);   wr(4'd6, 8'd0);
    wr(4'd8, 8'd63);  wr(4'd9, 8'd0);

    for (int i = 0; i < NV; i++) begin
      go_to(int'(VEC[i][20:11]), VEC[i][10], VEC[i][9], int'(VEC[i][8:1]));
      check(blank, VEC[i][0], $sformatf("R3/R5/R6/R7 vector %0d", i));
    end

    // R2 wrap: pixel 74 is count 10 after wrapping at 63
    go_to(1, 1'b1, 1'b0, 74);
    check(blank, 1'b0, "R2 counter wraps at last pixel");
    go_to(1, 1'b1, 1'b0, 71);
    check(blank, 1'b1, "R2 wrapped count 7 below end");

    // R4: simultaneous vsync and hsync give line 0, not 1
    wr(4'd3, 8'd0); wr(4'd4, 8'd0);
    wr(4'd5, 8'd1); wr(4'd6, 8'd0);
    go_to(0, 1'b1, 1'b0, 20);
    check(blank, 1'b1, "R4 vsync wins, line 0");
    go_to(1, 1'b1, 1'b0, 20);
    check(blank, 1'b0, "R4 line advances on hsync");
    wr(4'd5, 8'd9); wr(4'd6, 8'd0);
    wr(4'd3, 8'd5); wr(4'd4, 8'd0);

    // R8: low byte only staged
    wr(4'd0, 8'd5);
    go_to(1, 1'b1, 1'b0, 20);
    check(blank, 1'b0, "R8 low byte staged only");
    wr(4'd1, 8'd0);
    go_to(1, 1'b1, 1'b0, 20);
    check(blank, 1'b1, "R8 high byte commits");

    // R9: drive disabled hides active window
    wr(4'd7, 8'h00);
    go_to(1, 1'b1, 1'b0, 20);
    check(blank, 1'b0, "R9 blank low when disabled");
    check(blank_oe, 1'b0, "R9 oe low when disabled");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule